// File: doc/BRIEF.md
# I2C register-read target with retained address pointer

This block is an I2C target that gives a bus master access to a small byte-wide register file. SCL and SDA are sampled by a fast system clock. They pass through a synchroniser and edge detector, which find START, repeated START and STOP. The block compares the first byte of each transfer with a fixed 7-bit device address. The register file lives outside the block and is reached through a synchronous port: a strobe with an address returns data one cycle later, and a strobe with address and data performs a write. SDA is open drain, so the block only gives an active-high pull-low enable.

A write transfer uses its first data byte to load an internal word pointer. Any further bytes in that transfer are stored at the pointer, and each one advances it. A read transfer sends the byte at the pointer. The pointer moves to the next register only when the master acknowledges a byte. The pointer survives STOP, so a read may begin without loading it first. Each SDA change is held off for a programmable number of system clocks after SCL falls. This covers the slow falling edge of SCL.

Top module: `i2cr_target`

## Requirements
- R1: After reset, SDA is released (`sda_oe_o` = 0), no register strobe is active, and the word pointer is 0.
- R2: An address byte whose upper 7 bits equal `DEV_ADDR` is acknowledged by pulling SDA low in the 9th clock. Any other address is not acknowledged, and the block neither drives SDA nor strobes the register file until the next START.
- R3: In a write transfer (bit 0 of the address byte = 0), the first data byte is acknowledged and loaded into the pointer modulo `NUM_REGS`.
- R4: Each later data byte of the same write transfer is acknowledged, written to the register at the pointer, and then advances the pointer.
- R5: After a pointer load, a repeated START and an address byte with bit 0 = 1 make the block send the register at the pointer, MSB first.
- R6: During a read, a master ACK advances the pointer and the next register is sent. A master NACK leaves the pointer unchanged.
- R7: A read transfer that is not preceded by a pointer load starts at the pointer value retained from earlier transfers, including across STOP.
- R8: The pointer wraps from `NUM_REGS`-1 to 0, on both reads and writes.
- R9: `sda_oe_o` changes no sooner than `HOLD_CYC` system clocks after SCL falls. The only exception is the immediate release on START or STOP.
- R10: After a master NACK, SDA stays released and the bus is ignored until the next START or STOP.
- R11: STOP returns the block to idle, so clocked bits are ignored there. A START or repeated START always restarts address reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level sampled from the bus |
| sda_i | input | 1 | SDA level sampled from the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr_o | output | $clog2(NUM_REGS) | Register address for read or write strobe |
| reg_rd_en_o | output | 1 | Read strobe; data expected on reg_rd_data_i the next cycle |
| reg_rd_data_i | input | 8 | Read data from the register file |
| reg_wr_en_o | output | 1 | Write strobe |
| reg_wr_data_o | output | 8 | Write data |

## Verification
The tests cover these transfer shapes:
- A current-address read straight after reset, which shows that the pointer starts at 0 and is kept.
- A wrong address, which must give no acknowledge and no write.
- A pointer load followed by writes, with a pointer byte above `NUM_REGS`, so that the modulo load can be seen.
- Random and sequential reads that end in NACK, which separate "advance on ACK" from "advance on every byte".
- Transfers that cross the top register, which expose wrap errors in both directions.
- Clocking after a NACK and after STOP, which shows that idle is really idle.

The hold-off after each SCL fall is checked on every SDA change across the whole run.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_RX, S_SACK, S_TX, S_MACK
  } i2cr_state_t;

  // pointer successor with wrap at the last implemented register
  function automatic int unsigned ptr_succ(int unsigned p, int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

  // value loaded into the pointer from a received byte
  function automatic int unsigned ptr_from_byte(logic [7:0] b, int unsigned n);
    return int'(b) % n;
  endfunction

  function automatic logic addr_hit(logic [7:0] b, logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

endpackage

// File: rtl/i2cr_sync.sv
module i2cr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;
  logic scl_s;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
    end
  endgenerate

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2cr_ctrl.sv
module i2cr_ctrl
  import i2cr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int NUM_REGS = 16,
  parameter int HOLD_CYC = 8,
  localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int HW = $clog2(HOLD_CYC + 1),
  localparam int SW = $clog2(HOLD_CYC + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [7:0]    rd_data_i,
  output logic          sda_oe_o,
  output logic [AW-1:0] addr_o,
  output logic          rd_en_o,
  output logic          wr_en_o,
  output logic [7:0]    wdata_o
);
  localparam logic [AW-1:0] LAST = AW'(NUM_REGS - 1);

  i2cr_state_t st;
  logic [3:0]    cnt;
  logic [7:0]    sh, tx;
  logic          rw, ptr_set, m_ack, rd_q;
  logic [AW-1:0] ptr, ptr_nx;
  logic          want_low;
  logic [HW-1:0] hold;
  logic          hold_run;

  // named internal events
  logic byte_done, ptr_load_evt, wr_evt;

  assign ptr_nx       = AW'(ptr_succ(int'(ptr), NUM_REGS));
  assign byte_done    = scl_fall && (cnt == 4'd8);
  assign ptr_load_evt = (st == S_RX) && byte_done && !ptr_set;
  assign wr_evt       = (st == S_RX) && byte_done && ptr_set;

  always_comb
    want_low = (st == S_AACK) || (st == S_SACK) || ((st == S_TX) && !tx[7]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; tx <= 8'hFF;
      rw <= 1'b0; ptr_set <= 1'b0; m_ack <= 1'b0; rd_q <= 1'b0;
      ptr <= '0; addr_o <= '0; rd_en_o <= 1'b0; wr_en_o <= 1'b0; wdata_o <= '0;
    end else begin
      rd_en_o <= 1'b0;
      wr_en_o <= 1'b0;
      rd_q    <= rd_en_o;
      if (rd_q) tx <= rd_data_i;
      if (start_i) begin
        st <= S_ADDR; cnt <= '0; ptr_set <= 1'b0;
      end else if (stop_i) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_ADDR, S_RX: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (byte_done) begin
              if (st == S_ADDR) begin
                if (addr_hit(sh, DEV_ADDR)) begin
                  st <= S_AACK;
                  rw <= sh[0];
                  if (sh[0]) begin
                    rd_en_o <= 1'b1;
                    addr_o  <= ptr;
                  end
                end else begin
                  st <= S_IDLE;
                end
              end else begin
                st <= S_SACK;
                if (ptr_load_evt) begin
                  ptr     <= AW'(ptr_from_byte(sh, NUM_REGS));
                  ptr_set <= 1'b1;
                end else begin
                  wr_en_o <= 1'b1;
                  addr_o  <= ptr;
                  wdata_o <= sh;
                  ptr     <= ptr_nx;
                end
              end
            end
          end
          S_AACK, S_SACK: if (scl_fall) begin
            cnt <= '0;
            st  <= (st == S_AACK && rw) ? S_TX : S_RX;
          end
          S_TX: if (scl_fall) begin
            tx  <= {tx[6:0], 1'b1};
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) st <= S_MACK;
          end
          S_MACK: begin
            if (scl_rise) begin
              m_ack <= !sda_s;
              if (!sda_s) begin
                ptr     <= ptr_nx;
                rd_en_o <= 1'b1;
                addr_o  <= ptr_nx;
              end
            end else if (scl_fall) begin
              cnt <= '0;
              st  <= m_ack ? S_TX : S_IDLE;
            end
          end
          default: ;
        endcase
      end
    end

  // SDA output: applied HOLD_CYC cycles after each SCL fall, released at once on START/STOP
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sda_oe_o <= 1'b0; hold <= '0; hold_run <= 1'b0;
    end else if (start_i || stop_i) begin
      sda_oe_o <= 1'b0; hold_run <= 1'b0;
    end else if (scl_fall) begin
      hold <= HW'(HOLD_CYC); hold_run <= 1'b1;
    end else if (hold_run) begin
      if (hold == HW'(1)) begin
        sda_oe_o <= want_low;
        hold_run <= 1'b0;
      end else begin
        hold <= hold - HW'(1);
      end
    end

  // checker counter: cycles since last SCL fall, saturating
  logic [SW-1:0] since_fall;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since_fall <= SW'(HOLD_CYC);
    else if (scl_fall) since_fall <= '0;
    else if (since_fall != SW'(HOLD_CYC)) since_fall <= since_fall + SW'(1);

  p_hold_after_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe_o) && !$past(start_i || stop_i)) |-> (since_fall >= SW'(HOLD_CYC)));

  p_wrap_to_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ptr) == LAST && ptr != $past(ptr) && !$past(ptr_load_evt)) |-> (ptr == '0));

  p_single_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe_o);

endmodule

// File: rtl/i2cr_target.sv
module i2cr_target #(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int NUM_REGS    = 16,
  parameter int HOLD_CYC    = 8,
  parameter int SYNC_STAGES = 2,
  localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic [AW-1:0] reg_addr_o,
  output logic          reg_rd_en_o,
  input  logic [7:0]    reg_rd_data_i,
  output logic          reg_wr_en_o,
  output logic [7:0]    reg_wr_data_o
);
  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  i2cr_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2cr_ctrl #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .HOLD_CYC(HOLD_CYC)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_i(start_evt), .stop_i(stop_evt), .rd_data_i(reg_rd_data_i),
    .sda_oe_o(sda_oe_o), .addr_o(reg_addr_o), .rd_en_o(reg_rd_en_o),
    .wr_en_o(reg_wr_en_o), .wdata_o(reg_wr_data_o)
  );

endmodule

// File: tb/i2cr_target_tb.sv
module i2cr_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 40;
  localparam int NREG       = 16;
  localparam int HOLD       = 8;
  localparam logic [6:0] DEV = 7'h68;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  logic [3:0] r_addr;
  logic r_rd_en, r_wr_en;
  logic [7:0] r_rdata, r_wdata;
  logic sda_bus;

  assign sda_bus = m_sda & ~sda_oe;
  always #(CLK_PERIOD/2) clk = ~clk;

  i2cr_target #(.DEV_ADDR(DEV), .NUM_REGS(NREG), .HOLD_CYC(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .reg_addr_o(r_addr), .reg_rd_en_o(r_rd_en),
    .reg_rd_data_i(r_rdata), .reg_wr_en_o(r_wr_en), .reg_wr_data_o(r_wdata)
  );

  // register file model and expected image
  logic [7:0] mem [NREG];
  logic [7:0] em  [NREG];
  initial for (int i = 0; i < NREG; i++) mem[i] = 8'(i * 17 + 3);
  always @(posedge clk) begin
    if (r_rd_en) r_rdata <= mem[r_addr];
    if (r_wr_en) mem[r_addr] <= r_wdata;
  end

  // pin monitors
  int wr_cnt = 0, oe_cnt = 0, hold_viol = 0, oe_changes = 0, since_pin = 100;
  logic scl_prev = 1'b1, oe_prev = 1'b0;
  always @(posedge clk) begin
    if (r_wr_en) wr_cnt <= wr_cnt + 1;
    if (sda_oe)  oe_cnt <= oe_cnt + 1;
    since_pin <= (scl_prev && !m_scl) ? 0 : since_pin + 1;
    scl_prev  <= m_scl;
    oe_prev   <= sda_oe;
    if (sda_oe != oe_prev && !m_scl) begin
      oe_changes <= oe_changes + 1;
      if (since_pin < HOLD) hold_viol <= hold_viol + 1;
    end
  end

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bit_io(input logic b, output logic r);
    m_sda = b; wq(); m_scl = 1'b1; wq(); r = sda_bus; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(b[i], r);
    bit_io(1'b1, r);
    ack = !r;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, r); d[i] = r; end
    bit_io(!mack, r);
  endtask

  task automatic t_reset();
    logic a; logic [7:0] d;
    check("R1 sda released", 32'(sda_oe), 0);
    check("R1 rd strobe idle", 32'(r_rd_en), 0);
    check("R1 wr strobe idle", 32'(r_wr_en), 0);
    i2c_start(); wr_byte({DEV, 1'b1}, a);
    check("R2 own address acked", 32'(a), 1);
    rd_byte(1'b0, d); i2c_stop();
    check("R1 pointer starts at 0", 32'(d), 32'(em[0]));
  endtask

  task automatic t_mismatch();
    logic a; logic [7:0] d; int oe0, wr0;
    i2c_start(); wr_byte({7'h11, 1'b0}, a);
    check("R2 foreign address not acked", 32'(a), 0);
    oe0 = oe_cnt; wr0 = wr_cnt;
    wr_byte(8'h09, a); i2c_stop();
    check("R2 no drive after mismatch", 32'(oe_cnt - oe0), 0);
    check("R2 no write after mismatch", 32'(wr_cnt - wr0), 0);
    i2c_start(); wr_byte({DEV, 1'b1}, a); rd_byte(1'b0, d); i2c_stop();
    check("R7 pointer kept after mismatch", 32'(d), 32'(em[0]));
  endtask

  task automatic t_write();
    logic a; logic [7:0] d; int wr0;
    wr0 = wr_cnt;
    i2c_start(); wr_byte({DEV, 1'b0}, a);
    wr_byte(8'h25, a); check("R3 pointer byte acked", 32'(a), 1);
    wr_byte(8'hA1, a); check("R4 data byte acked", 32'(a), 1);
    wr_byte(8'hB2, a); wr_byte(8'hC3, a); i2c_stop();
    em[5] = 8'hA1; em[6] = 8'hB2; em[7] = 8'hC3;
    check("R4 write count", 32'(wr_cnt - wr0), 3);
    check("R4 reg5 written", 32'(mem[5]), 32'hA1);
    check("R4 reg7 written", 32'(mem[7]), 32'hC3);
    i2c_start(); wr_byte({DEV, 1'b1}, a); rd_byte(1'b0, d); i2c_stop();
    check("R7 current read after writes", 32'(d), 32'(em[8]));
  endtask

  task automatic t_random_seq();
    logic a; logic [7:0] d;
    i2c_start(); wr_byte({DEV, 1'b0}, a); wr_byte(8'h05, a);
    i2c_start(); wr_byte({DEV, 1'b1}, a);
    check("R5 read address acked", 32'(a), 1);
    rd_byte(1'b1, d); check("R5 random read", 32'(d), 32'(em[5]));
    rd_byte(1'b1, d); check("R6 sequential 1", 32'(d), 32'(em[6]));
    rd_byte(1'b1, d); check("R6 sequential 2", 32'(d), 32'(em[7]));
    rd_byte(1'b0, d); check("R6 sequential 3", 32'(d), 32'(em[8]));
    i2c_stop();
    i2c_start(); wr_byte({DEV, 1'b1}, a); rd_byte(1'b0, d); i2c_stop();
    check("R6 NACK leaves pointer", 32'(d), 32'(em[8]));
  endtask

  task automatic t_wrap();
    logic a; logic [7:0] d;
    i2c_start(); wr_byte({DEV, 1'b0}, a); wr_byte(8'h0E, a);
    i2c_start(); wr_byte({DEV, 1'b1}, a);
    rd_byte(1'b1, d); check("R8 read reg14", 32'(d), 32'(em[14]));
    rd_byte(1'b1, d); check("R8 read reg15", 32'(d), 32'(em[15]));
    rd_byte(1'b1, d); check("R8 read wraps to reg0", 32'(d), 32'(em[0]));
    rd_byte(1'b0, d); check("R8 read reg1", 32'(d), 32'(em[1]));
    i2c_stop();
    i2c_start(); wr_byte({DEV, 1'b0}, a); wr_byte(8'h0F, a);
    wr_byte(8'h5A, a); wr_byte(8'h6B, a); i2c_stop();
    em[15] = 8'h5A; em[0] = 8'h6B;
    check("R8 write reg15", 32'(mem[15]), 32'h5A);
    check("R8 write wraps to reg0", 32'(mem[0]), 32'h6B);
  endtask

  task automatic t_nack_ignore();
    logic a; logic [7:0] d; int oe0;
    i2c_start(); wr_byte({DEV, 1'b0}, a); wr_byte(8'h23, a);
    i2c_start(); wr_byte({DEV, 1'b1}, a); rd_byte(1'b0, d);
    check("R3 pointer loaded modulo", 32'(d), 32'(em[3]));
    oe0 = oe_cnt;
    rd_byte(1'b0, d);
    check("R10 bus released after NACK", 32'(d), 32'hFF);
    check("R10 no drive after NACK", 32'(oe_cnt - oe0), 0);
    i2c_start(); wr_byte({DEV, 1'b1}, a);
    check("R11 repeated START restarts", 32'(a), 1);
    rd_byte(1'b0, d); i2c_stop();
    check("R10 ignored clocks keep pointer", 32'(d), 32'(em[3]));
  endtask

  task automatic t_after_stop();
    logic a; logic [7:0] d; int wr0;
    i2c_start(); wr_byte({DEV, 1'b0}, a); wr_byte(8'h02, a); wr_byte(8'h77, a);
    i2c_stop(); em[2] = 8'h77;
    wr0 = wr_cnt;
    m_scl = 1'b0; wq();
    wr_byte(8'h55, a);
    check("R11 idle after STOP not acked", 32'(a), 0);
    check("R11 no write after STOP", 32'(wr_cnt - wr0), 0);
    i2c_start(); wr_byte({DEV, 1'b0}, a); wr_byte(8'h02, a);
    i2c_start(); wr_byte({DEV, 1'b1}, a); rd_byte(1'b0, d); i2c_stop();
    check("R4 stored byte read back", 32'(d), 32'h77);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) em[i] = 8'(i * 17 + 3);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_mismatch();
    t_write();
    t_random_seq();
    t_wrap();
    t_nack_ignore();
    t_after_stop();
    check("R9 hold-off violations", 32'(hold_viol), 0);
    check("R9 sda changes observed", 32'(oe_changes > 0), 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule